// File: doc/BRIEF.md
# Phased Serial Priority Interrupt Arbiter

This block decides which interrupt the processor takes next. It runs all the time, whatever the processor is executing. Up to eight maskable channels each carry a 3-bit priority written by software. The processor's current priority level (CPL) competes with them in the same comparison. A channel is granted only when its level is strictly above the CPL. The contest is spread over fixed one-clock phases. The set of contenders is frozen in a start phase. One phase per priority bit then removes the losers, most significant bit first. A pick phase names the winner. A single acknowledge cycle follows only when something won. A new round starts at once after every round.

There is also a top-level (non-maskable) channel, driven by one of two sources. The first is an external pin with a selectable active edge, passed through a synchroniser. The second is a one-clock end-of-count pulse from a watchdog timer. This channel has a late way into the round: if it is pending by the last priority-bit phase, it wins at the very next pick phase. It beats every programmed priority and ignores the CPL.

The block's outputs are a one-cycle acknowledge strobe, the winning channel index and a flag that marks a top-level grant. Vector fetch and context saving belong to the processor and are not part of this block.

Top module: `phased_irq_arbiter`

## Requirements
- R1: While reset is high, and during the first cycle after it is released, `ack_o`, `ack_idx_o` and `ack_tl_o` are all zero. The first cycle after reset is a start phase (A).
- R2: A round is made of these phases, one clock each: A, then B, C and D (which resolve priority bits 2, 1 and 0), then the pick phase E. If a winner is found in E, a single acknowledge cycle F follows, and in F `ack_o` is 1. Otherwise A follows E directly. Acknowledges are never on two consecutive cycles. Two requests already pending are acknowledged 6 clocks apart.
- R3: A maskable channel is granted only if its priority is strictly greater than `cpl_i`. A channel whose priority equals the CPL, or is below it, stays pending and is not granted.
- R4: Channel i takes its priority from `prio_i[3*i+2:3*i]`. Among the contenders the highest priority wins. When priorities are equal, the lowest channel index wins. `ack_idx_o` carries the winner's index.
- R5: The contender set is captured at the end of phase A. Take a `req_i` pulse presented in the cycle of phase E. It is acknowledged 6 clocks later, with `ack_o` high in the sixth cycle after the pulse. A pulse presented during phase A misses that round and is acknowledged 10 clocks later.
- R6: A one-cycle `req_i[i]` pulse makes channel i pending. The channel stays pending until the end of its acknowledge cycle. A new pulse in that acknowledge cycle keeps it pending, and it is then acknowledged again 6 clocks later. A single pulse produces exactly one acknowledge.
- R7: A top-level event that is pending in phase D, or arrives in phase D, wins at the E of the same round. The result is `ack_o`=1, `ack_tl_o`=1 and `ack_idx_o`=0, whatever the channel priorities and the CPL. A watchdog pulse in phase D is acknowledged 2 clocks later. One in phase C is acknowledged 3 clocks later.
- R8: A top-level event that arrives in phase E waits for the following round. It is acknowledged 6 clocks later.
- R9: `tl_sel_wdg_i`=0 selects the pin as the top-level source, and `tl_sel_wdg_i`=1 selects `wdg_eoc_i`. The source that is not selected has no effect.
- R10: `nmi_rise_i`=1 makes a rising pin edge the trigger, and `nmi_rise_i`=0 a falling one. The opposite edge has no effect. The pin passes through two synchroniser flops, so a pin change in cycle 0 first makes the top-level channel pending in cycle 3.
- R11: When the top-level channel and a maskable channel both contend in the same round, the top-level channel is acknowledged first. The maskable channel stays pending and is acknowledged in the next round, 6 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NCH | One-cycle request pulse per maskable channel |
| prio_i | input | NCH*PW | Packed per-channel priority levels, channel 0 in the low bits |
| cpl_i | input | PW | Current processor priority level |
| nmi_pin_i | input | 1 | Asynchronous top-level pin |
| nmi_rise_i | input | 1 | 1: rising edge triggers, 0: falling edge triggers |
| wdg_eoc_i | input | 1 | Watchdog end-of-count pulse |
| tl_sel_wdg_i | input | 1 | Top-level source: 0 pin, 1 watchdog |
| ack_o | output | 1 | One-cycle acknowledge strobe (phase F) |
| ack_idx_o | output | IW | Index of the acknowledged channel, 0 for a top-level grant |
| ack_tl_o | output | 1 | Acknowledge belongs to the top-level channel |

## Verification
Every result is due at a fixed offset from its stimulus, and that offset depends on the phase the stimulus lands in. A maskable pulse is acknowledged after 6 clocks if it arrives in E and after 10 if it arrives in A. A watchdog event is acknowledged after 2, 3 or 6 clocks if it arrives in D, C or E. A pin change takes three cycles to become pending. The bench finds out the current phase from its own behavioural model, which advances on every rising edge. It places each stimulus in a chosen phase, and on each falling edge it counts the cycles until `ack_o` rises and compares that count with the number the requirement gives. In the same falling edge it also compares the three outputs with the model, so an acknowledge that comes one cycle early or late, or carries a wrong index, is caught in the very cycle it appears.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  // Round phases: start, one phase per priority bit, pick, acknowledge.
  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_BIT   = 2'd1,
    PH_PICK  = 2'd2,
    PH_ACK   = 2'd3
  } phase_e;

endpackage

// File: rtl/irq_phase_seq.sv
module irq_phase_seq
  import irq_arb_pkg::*;
#(
  parameter int PW = 3,
  localparam int BW = (PW > 1) ? $clog2(PW) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          grant_i,
  output phase_e        phase_o,
  output logic [BW-1:0] bit_o,
  output logic          last_bit_o
);

  phase_e        ph_q;
  logic [BW-1:0] bit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_START;
      bit_q <= BW'(PW - 1);
    end else begin
      case (ph_q)
        PH_START: begin
          ph_q  <= PH_BIT;
          bit_q <= BW'(PW - 1);
        end
        PH_BIT: begin
          if (bit_q == '0) ph_q <= PH_PICK;
          else             bit_q <= bit_q - 1'b1;
        end
        PH_PICK: ph_q <= grant_i ? PH_ACK : PH_START;
        default: ph_q <= PH_START;
      endcase
    end
  end

  assign phase_o    = ph_q;
  assign bit_o      = bit_q;
  assign last_bit_o = (ph_q == PH_BIT) && (bit_q == '0);

endmodule

// File: rtl/irq_prio_filter.sv
module irq_prio_filter
  import irq_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int PW  = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW = (PW > 1) ? $clog2(PW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  phase_e          phase_i,
  input  logic [BW-1:0]   bit_i,
  input  logic [NCH-1:0]  pend_i,
  input  logic [NCH*PW-1:0] prio_i,
  input  logic [PW-1:0]   cpl_i,
  output logic            win_valid_o,
  output logic [IW-1:0]   win_idx_o
);

  logic [NCH-1:0] cand_q;
  logic           cpu_q;
  logic [NCH-1:0] chan_bit;
  logic           cpu_bit;
  logic           any_one;

  // Pick out the currently resolved bit of every channel's level.
  for (genvar g = 0; g < NCH; g++) begin : g_bit
    logic [PW-1:0] lvl;
    assign lvl         = prio_i[g*PW +: PW];
    assign chan_bit[g] = lvl[bit_i];
  end

  assign cpu_bit = cpl_i[bit_i];
  assign any_one = (cpu_q & cpu_bit) | (|(cand_q & chan_bit));

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      cpu_q  <= 1'b1;
    end else begin
      case (phase_i)
        PH_START: begin
          cand_q <= pend_i;
          cpu_q  <= 1'b1;
        end
        PH_BIT: begin
          // Contenders with a zero drop out when anyone shows a one.
          if (any_one) begin
            cand_q <= cand_q & chan_bit;
            cpu_q  <= cpu_q & cpu_bit;
          end
        end
        default: ;
      endcase
    end
  end

  // CPL survives a tie, so a grant needs a strictly higher level.
  assign win_valid_o = !cpu_q && (|cand_q);

  always_comb begin
    win_idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cand_q[i]) win_idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irq_toplevel_src.sv
module irq_toplevel_src #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic rise_i,
  input  logic wdg_i,
  input  logic sel_wdg_i,
  input  logic clr_i,
  output logic event_o,
  output logic pend_o
);

  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            pend_q;
  logic            cur;
  logic            pin_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], pin_i};
      prev_q <= sync_q[SYNC-1];
    end
  end

  assign cur      = sync_q[SYNC-1];
  assign pin_edge = rise_i ? (cur & ~prev_q) : (~cur & prev_q);
  assign event_o  = sel_wdg_i ? wdg_i : pin_edge;

  // A fresh event outweighs a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q & ~clr_i) | event_o;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/phased_irq_arbiter.sv
module phased_irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int PW   = 3,
  parameter int SYNC = 2,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int BW  = (PW > 1) ? $clog2(PW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH*PW-1:0] prio_i,
  input  logic [PW-1:0]     cpl_i,
  input  logic              nmi_pin_i,
  input  logic              nmi_rise_i,
  input  logic              wdg_eoc_i,
  input  logic              tl_sel_wdg_i,
  output logic              ack_o,
  output logic [IW-1:0]     ack_idx_o,
  output logic              ack_tl_o
);

  phase_e         phase_w;
  logic [BW-1:0]  bit_w;
  logic           last_bit_w;
  logic           grant_w;
  logic           win_valid_w;
  logic [IW-1:0]  win_idx_w;
  logic           tl_event_w;
  logic           tl_pend_w;
  logic           tl_cand_q;
  logic [NCH-1:0] pend_q;
  logic [NCH-1:0] clr_mask;
  logic           ack_q;
  logic           tl_q;
  logic [IW-1:0]  idx_q;

  irq_phase_seq #(.PW(PW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .grant_i    (grant_w),
    .phase_o    (phase_w),
    .bit_o      (bit_w),
    .last_bit_o (last_bit_w)
  );

  irq_prio_filter #(.NCH(NCH), .PW(PW)) u_filter (
    .clk         (clk),
    .rst         (rst),
    .phase_i     (phase_w),
    .bit_i       (bit_w),
    .pend_i      (pend_q),
    .prio_i      (prio_i),
    .cpl_i       (cpl_i),
    .win_valid_o (win_valid_w),
    .win_idx_o   (win_idx_w)
  );

  irq_toplevel_src #(.SYNC(SYNC)) u_tl (
    .clk       (clk),
    .rst       (rst),
    .pin_i     (nmi_pin_i),
    .rise_i    (nmi_rise_i),
    .wdg_i     (wdg_eoc_i),
    .sel_wdg_i (tl_sel_wdg_i),
    .clr_i     (ack_q & tl_q),
    .event_o   (tl_event_w),
    .pend_o    (tl_pend_w)
  );

  // Late entry: top-level state is sampled in the last bit phase.
  always_ff @(posedge clk) begin
    if (rst)                               tl_cand_q <= 1'b0;
    else if (phase_w == PH_START)          tl_cand_q <= 1'b0;
    else if (last_bit_w)                   tl_cand_q <= tl_pend_w | tl_event_w;
  end

  assign grant_w  = (phase_w == PH_PICK) && (tl_cand_q || win_valid_w);
  assign clr_mask = (ack_q && !tl_q) ? (NCH'(1) << idx_q) : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_mask) | req_i;
  end

  always_ff @(posedge clk) begin
    if (rst || !grant_w) begin
      ack_q <= 1'b0;
      tl_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      ack_q <= 1'b1;
      tl_q  <= tl_cand_q;
      idx_q <= tl_cand_q ? '0 : win_idx_w;
    end
  end

  assign ack_o     = ack_q;
  assign ack_tl_o  = tl_q;
  assign ack_idx_o = idx_q;

endmodule

// File: rtl/irq_arb_checker.sv
module irq_arb_checker
  import irq_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int IW  = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           ack_o,
  input logic [IW-1:0]  ack_idx_o,
  input logic           ack_tl_o,
  input phase_e         phase_q,
  input logic [NCH-1:0] pend_q,
  input logic           tl_pend_q
);

  // R2: an acknowledge lasts exactly one cycle
  a_r2_single_ack: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  // R2: an acknowledge only follows a pick phase
  a_r2_after_pick: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(phase_q == PH_PICK));

  // R6: a granted maskable channel is still pending in its ack cycle
  a_r6_grant_pending: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !ack_tl_o) |-> pend_q[ack_idx_o]);

  // R7: a top-level grant reports index zero with the strobe
  a_r7_tl_index: assert property (@(posedge clk) disable iff (rst)
    ack_tl_o |-> (ack_o && ack_idx_o == '0));

  // R8: a top-level grant needs a pending top-level event
  a_r8_tl_pending: assert property (@(posedge clk) disable iff (rst)
    ack_tl_o |-> tl_pend_q);

endmodule

bind phased_irq_arbiter irq_arb_checker #(.NCH(NCH), .IW(IW)) u_irq_arb_checker (
  .clk       (clk),
  .rst       (rst),
  .ack_o     (ack_o),
  .ack_idx_o (ack_idx_o),
  .ack_tl_o  (ack_tl_o),
  .phase_q   (phase_w),
  .pend_q    (pend_q),
  .tl_pend_q (tl_pend_w)
);

// File: tb/phased_irq_arbiter_bench.sv
`timescale 1ns/1ps
module phased_irq_arbiter_bench;

  localparam int NCH = 8;
  localparam int PW  = 3;
  localparam int IW  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NCH-1:0]    req = '0;
  logic [NCH*PW-1:0] prio;
  logic [PW-1:0]     cpl = '0;
  logic              pin = 1'b0;
  logic              rise = 1'b1;
  logic              wdg = 1'b0;
  logic              sel = 1'b0;
  logic              ack_o;
  logic [IW-1:0]     ack_idx_o;
  logic              ack_tl_o;

  int p [NCH] = '{3, 5, 5, 1, 7, 2, 0, 4};
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) prio[i*PW +: PW] = PW'(p[i]);
  end

  phased_irq_arbiter u_phased_irq_arbiter (
    .clk(clk), .rst(rst), .req_i(req), .prio_i(prio), .cpl_i(cpl),
    .nmi_pin_i(pin), .nmi_rise_i(rise), .wdg_eoc_i(wdg), .tl_sel_wdg_i(sel),
    .ack_o(ack_o), .ack_idx_o(ack_idx_o), .ack_tl_o(ack_tl_o)
  );

  // Behavioural reference: phase counter 0..5 = A..F, best-level search in E.
  int m_ph;
  bit m_pend [NCH];
  bit m_cand [NCH];
  bit m_tlc, m_tlp, s1, s2, s3;
  bit m_ack, m_tl;
  int m_idx;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_tlc = 0; m_tlp = 0; s1 = 0; s2 = 0; s3 = 0;
      m_ack = 0; m_tl = 0; m_idx = 0;
      for (int i = 0; i < NCH; i++) begin m_pend[i] = 0; m_cand[i] = 0; end
    end else begin
      bit ev, n_ack, n_tl;
      int n_idx, best;
      ev = sel ? wdg : (rise ? (s2 && !s3) : (!s2 && s3));
      n_ack = 0; n_tl = 0; n_idx = 0;
      if (m_ph == 0) for (int i = 0; i < NCH; i++) m_cand[i] = m_pend[i];
      if (m_ph == 3) m_tlc = m_tlp || ev;
      if (m_ph == 4) begin
        best = -1;
        for (int i = 0; i < NCH; i++) if (m_cand[i] && p[i] > best) best = p[i];
        if (m_tlc) begin
          n_ack = 1; n_tl = 1;
        end else if (best > int'(cpl)) begin
          n_ack = 1;
          for (int i = NCH - 1; i >= 0; i--) if (m_cand[i] && p[i] == best) n_idx = i;
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (m_ack && !m_tl && m_idx == i) m_pend[i] = 0;
        if (req[i]) m_pend[i] = 1;
      end
      if (m_ack && m_tl) m_tlp = 0;
      if (ev) m_tlp = 1;
      s3 = s2; s2 = s1; s1 = pin;
      if (m_ph < 4)       m_ph = m_ph + 1;
      else if (m_ph == 4) m_ph = n_ack ? 5 : 0;
      else                m_ph = 0;
      m_ack = n_ack; m_tl = n_tl; m_idx = n_idx;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (ack_o !== m_ack || ack_tl_o !== m_tl || int'(ack_idx_o) != m_idx) begin
        fails++;
        $display("FAIL R2 cycle model: ack/idx/tl got %b/%0d/%b exp %b/%0d/%b",
                 ack_o, ack_idx_o, ack_tl_o, m_ack, m_idx, m_tl);
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d exp %0d", rq, what, got, exp);
    end
  endtask

  task automatic wait_phase(input int ph);
    do @(negedge clk); while (m_ph != ph);
  endtask

  // Present a one-cycle stimulus now, then count falling edges to the next ack.
  task automatic stim(input logic [NCH-1:0] rq, input logic wd, input int maxc,
                      output int n, output int idx, output int tl);
    req = rq; wdg = wd; n = 0; idx = -1; tl = 0;
    while (n <= maxc) begin
      @(negedge clk);
      n++; req = '0; wdg = 1'b0;
      if (ack_o) begin idx = int'(ack_idx_o); tl = int'(ack_tl_o); break; end
    end
    if (idx < 0) n = -1;
  endtask

  task automatic drain();
    repeat (30) @(negedge clk);
  endtask

  initial begin
    int n, idx, tl;
    repeat (4) @(negedge clk);
    chk(ack_o == 0 && ack_tl_o == 0 && ack_idx_o == 0, "R1", "outputs in reset", int'(ack_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ack_o == 0 && ack_idx_o == 0 && ack_tl_o == 0, "R1", "outputs after reset", int'(ack_o), 0);
    chk(m_ph == 1, "R1", "first post-reset phase was A", m_ph, 1);

    // R5 best case: pulse in E
    wait_phase(4);
    stim(8'h02, 0, 20, n, idx, tl);
    chk(n == 6, "R5", "latency pulse in E", n, 6);
    chk(idx == 1, "R5", "index", idx, 1);
    drain();
    // R5 worst case: pulse in A
    wait_phase(0);
    stim(8'h80, 0, 20, n, idx, tl);
    chk(n == 10, "R5", "latency pulse in A", n, 10);
    chk(idx == 7, "R5", "index", idx, 7);
    drain();

    // R4 priority and tie order, R2 spacing
    wait_phase(4);
    stim(8'h07, 0, 20, n, idx, tl);
    chk(idx == 1, "R4", "highest level, lowest index", idx, 1);
    stim('0, 0, 20, n, idx, tl);
    chk(idx == 2, "R4", "tie partner next", idx, 2);
    chk(n == 6, "R2", "ack spacing", n, 6);
    stim('0, 0, 20, n, idx, tl);
    chk(idx == 0, "R4", "lowest level last", idx, 0);
    drain();

    // R3 strictly above CPL
    wait_phase(0); cpl = 3'd5;
    wait_phase(4);
    stim(8'h04, 0, 20, n, idx, tl);
    chk(n == -1, "R3", "equal to CPL not granted", n, -1);
    wait_phase(4);
    stim(8'h10, 0, 20, n, idx, tl);
    chk(idx == 4, "R3", "above CPL granted", idx, 4);
    wait_phase(0); cpl = 3'd4;
    stim('0, 0, 20, n, idx, tl);
    chk(idx == 2, "R3", "granted once CPL lowered", idx, 2);
    drain();

    // R7 top-level overrides CPL and levels
    sel = 1'b1;
    wait_phase(0); cpl = 3'd7;
    wait_phase(4);
    stim(8'h10, 0, 15, n, idx, tl);
    chk(n == -1, "R3", "level 7 with CPL 7 not granted", n, -1);
    wait_phase(3);
    stim('0, 1, 20, n, idx, tl);
    chk(n == 2, "R7", "watchdog in D latency", n, 2);
    chk(tl == 1 && idx == 0, "R7", "top-level flag/index", tl, 1);
    wait_phase(0); cpl = 3'd0;
    stim('0, 0, 20, n, idx, tl);
    chk(idx == 4 && tl == 0, "R7", "maskable kept pending", idx, 4);
    drain();

    // R11 top-level first, maskable next round
    wait_phase(4);
    req = 8'h02; @(negedge clk); req = '0;
    wait_phase(3);
    stim('0, 1, 20, n, idx, tl);
    chk(n == 2 && tl == 1, "R11", "top-level served first", tl, 1);
    stim('0, 0, 20, n, idx, tl);
    chk(idx == 1 && n == 6, "R11", "maskable 6 clocks later", n, 6);
    drain();

    // R8 late arrival, R7 in C
    wait_phase(4);
    stim('0, 1, 20, n, idx, tl);
    chk(n == 6 && tl == 1, "R8", "watchdog in E latency", n, 6);
    drain();
    wait_phase(2);
    stim('0, 1, 20, n, idx, tl);
    chk(n == 3 && tl == 1, "R7", "watchdog in C latency", n, 3);
    drain();

    // R6 re-request in ack cycle, then single ack
    wait_phase(4);
    stim(8'h20, 0, 20, n, idx, tl);
    chk(idx == 5, "R6", "first ack", idx, 5);
    stim(8'h20, 0, 20, n, idx, tl);
    chk(idx == 5 && n == 6, "R6", "pulse in ack cycle re-acked", n, 6);
    stim('0, 0, 20, n, idx, tl);
    chk(n == -1, "R6", "no further ack", n, -1);

    // R9 unselected source ignored
    sel = 1'b1;
    @(negedge clk); pin = 1'b1;
    stim('0, 0, 12, n, idx, tl);
    pin = 1'b0;
    stim('0, 0, 20, n, idx, tl);
    chk(n == -1, "R9", "pin ignored with watchdog selected", n, -1);
    sel = 1'b0;
    stim('0, 1, 20, n, idx, tl);
    chk(n == -1, "R9", "watchdog ignored with pin selected", n, -1);

    // R10 edge polarity
    rise = 1'b1; pin = 1'b1;
    stim('0, 0, 20, n, idx, tl);
    chk(tl == 1, "R10", "rising edge triggers", tl, 1);
    drain();
    pin = 1'b0;
    stim('0, 0, 20, n, idx, tl);
    chk(n == -1, "R10", "falling edge ignored when rising chosen", n, -1);
    rise = 1'b0;
    @(negedge clk); pin = 1'b1;
    stim('0, 0, 20, n, idx, tl);
    chk(n == -1, "R10", "rising edge ignored when falling chosen", n, -1);
    pin = 1'b0;
    stim('0, 0, 20, n, idx, tl);
    chk(tl == 1, "R10", "falling edge triggers", tl, 1);
    drain();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R2 watchdog expired: got hang exp completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule